// File: doc/BRIEF.md
# Vector Arc Operand Queue Manager

This block keeps the operand bookkeeping for the two-operand vector nodes of a dataflow processing element. Every arc that feeds a node operand can hold any number of vector pointers, kept in arrival order. An update port delivers one vector pointer for a chosen node and operand port. A node becomes enabled when both of its operand arcs hold at least one pointer. Its address then goes into an internal ready queue, and the head of that queue is presented to the fetch logic together with the two operand pointers it will use.

When the fetch logic takes the head entry, the oldest pointer on each of the node's two arcs is consumed. If both arcs still hold pointers afterwards, the node goes back into the ready queue at once. Several activations of one node can therefore be issued back to back without any further external update. Pending pointers live in a shared link table. Per-operand head and tail indices chain that table into one FIFO per arc, and free slots are kept on a stack.

Top module: `vec_arc_queue`

## Requirements
- R1: After reset the ready queue is empty (`rdyValid` = 0), no arc holds a pointer, and `updReady` = 1.
- R2: `updPort` 0 addresses operand A and 1 addresses operand B. An accepted update that gives a node its second present operand puts the node into the ready queue, visible on the outputs one cycle after the accepting edge. A node is never in the ready queue more than once.
- R3: Pointers on one arc are consumed strictly in arrival order. While `rdyValid` is 1, `rdyOpA` and `rdyOpB` show the oldest pending pointer on each arc of `rdyNode`.
- R4: `rdyPop` while `rdyValid` is 1 dispatches the head node and consumes one pointer from each of its arcs. If both arcs still hold pointers, the node is appended once to the tail of the ready queue.
- R5: If a dispatch leaves either arc of the node empty, the node is not re-enqueued. A later update that refills the empty arc enables it again.
- R6: The ready queue is first-in first-out. When a dispatch re-enqueue and an update-driven enable occur in the same cycle, the dispatched node is placed ahead of the updated node.
- R7: When an update and a dispatch hit the same arc in the same cycle, the consumption is applied first and the append second. The arc stays a consistent FIFO, including when the consumption empties it.
- R8: When every link-table slot is occupied, `updReady` is 0 and a presented update is not taken.
- R9: When the ready queue is full, `updReady` is 0 and a presented update is not taken.
- R10: `rdyPop` while the ready queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| updValid | input | 1 | Update request |
| updReady | output | 1 | Update can be accepted this cycle |
| updNode | input | NODE_W (3) | Destination node address |
| updPort | input | 1 | Destination operand: 0 = A, 1 = B |
| updPtr | input | PTR_W (8) | Vector pointer to queue |
| rdyValid | output | 1 | Ready queue not empty |
| rdyNode | output | NODE_W (3) | Node address at the head of the ready queue |
| rdyOpA | output | PTR_W (8) | Oldest pointer on operand A of `rdyNode` |
| rdyOpB | output | PTR_W (8) | Oldest pointer on operand B of `rdyNode` |
| rdyPop | input | 1 | Dispatch the head node |

## Verification
Every output is a function of registered state, so each accepted update or dispatch shows its effect in the cycle after the clock edge that took it, and never in the same cycle. The reference model in the bench applies each stimulus at the same rising edge as the design. Outputs are compared at the following falling edge, once the registers have settled and before the driver changes any input. This timing covers `rdyNode`, the two head pointers and `updReady` alike. Directed checks of each scenario's end state are sampled at that same falling edge.

// File: rtl/vaq_pkg.sv
package vaq_pkg;
  // strobes from control to datapath, one cycle's worth of work
  typedef struct packed {
    logic doUpd;     // append updPtr to the addressed arc
    logic doDisp;    // consume the head node's two operands
    logic pushDisp;  // re-enqueue the dispatched node
    logic pushUpd;   // enqueue the node that became enabled by the update
  } vaqStrobe_t;
endpackage

// File: rtl/vaq_ctrl.sv
module vaq_ctrl
  import vaq_pkg::*;
#(
  parameter int NODES    = 8,
  parameter int LINKS    = 16,
  parameter int RQ_DEPTH = 4,
  localparam int NODE_W  = $clog2(NODES),
  localparam int RQ_CW   = $clog2(RQ_DEPTH) + 1,
  localparam int FREE_W  = $clog2(LINKS) + 1
) (
  input  logic               updValid,
  input  logic [NODE_W-1:0]  updNode,
  input  logic               updPort,
  input  logic               rdyPop,
  input  logic [2*NODES-1:0] presVec,
  input  logic [2*NODES-1:0] singleVec,
  input  logic [NODE_W-1:0]  headNode,
  input  logic [RQ_CW-1:0]   rqCnt,
  input  logic [FREE_W-1:0]  freeCnt,
  output logic               updReady,
  output vaqStrobe_t         strobe
);
  logic hitHead;
  logic keepA;
  logic keepB;

  always_comb begin
    updReady      = (freeCnt != '0) && (rqCnt != RQ_CW'(RQ_DEPTH));
    strobe.doUpd  = updValid && updReady;
    strobe.doDisp = rdyPop && (rqCnt != '0);
    // update lands on the node being dispatched this cycle
    hitHead = strobe.doDisp && strobe.doUpd && (updNode == headNode);
    // each arc of the dispatched node still holds a pointer after pop+append
    keepA = !singleVec[{headNode, 1'b0}] || (hitHead && !updPort);
    keepB = !singleVec[{headNode, 1'b1}] || (hitHead && updPort);
    strobe.pushDisp = strobe.doDisp && keepA && keepB;
    // plain enable: this arc was empty, the other arc already present
    strobe.pushUpd = strobe.doUpd && !hitHead
                   && !presVec[{updNode, updPort}]
                   && presVec[{updNode, !updPort}];
  end
endmodule

// File: rtl/vaq_dpath.sv
module vaq_dpath
  import vaq_pkg::*;
#(
  parameter int NODES    = 8,
  parameter int PTR_W    = 8,
  parameter int LINKS    = 16,
  parameter int RQ_DEPTH = 4,
  localparam int NODE_W  = $clog2(NODES),
  localparam int OPS     = 2 * NODES,
  localparam int LINK_W  = $clog2(LINKS),
  localparam int FREE_W  = LINK_W + 1,
  localparam int RQ_W    = $clog2(RQ_DEPTH),
  localparam int RQ_CW   = RQ_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  vaqStrobe_t        strobe,
  input  logic [NODE_W-1:0] updNode,
  input  logic              updPort,
  input  logic [PTR_W-1:0]  updPtr,
  output logic [OPS-1:0]    presVec,
  output logic [OPS-1:0]    singleVec,
  output logic [NODE_W-1:0] headNode,
  output logic [RQ_CW-1:0]  rqCnt,
  output logic [FREE_W-1:0] freeCnt,
  output logic [PTR_W-1:0]  headOpA,
  output logic [PTR_W-1:0]  headOpB
);
  // operand table: presence plus first/last link index per arc
  logic [OPS-1:0]    opPres;
  logic [LINK_W-1:0] opHead [OPS];
  logic [LINK_W-1:0] opTail [OPS];
  // link table holding the queued pointers and their chain
  logic [PTR_W-1:0]  linkVal [LINKS];
  logic [LINK_W-1:0] linkNxt [LINKS];
  // free-slot stack
  logic [LINK_W-1:0] freeStk [LINKS];
  // ready queue of node addresses (RQ_DEPTH a power of two, at least 2)
  logic [NODE_W-1:0] rq [RQ_DEPTH];
  logic [RQ_W-1:0]   rqRd;
  logic [RQ_W-1:0]   rqWr;

  logic [NODE_W:0]   dIdxA, dIdxB, uIdx;
  logic [LINK_W-1:0] freedA, freedB, allocIdx;
  logic [FREE_W-1:0] spAfter;
  logic              emptiesU;

  assign presVec  = opPres;
  assign headNode = rq[rqRd];

  for (genvar i = 0; i < OPS; i++) begin : g_single
    assign singleVec[i] = (opHead[i] == opTail[i]);
  end

  always_comb begin
    dIdxA    = {headNode, 1'b0};
    dIdxB    = {headNode, 1'b1};
    uIdx     = {updNode, updPort};
    freedA   = opHead[dIdxA];
    freedB   = opHead[dIdxB];
    allocIdx = freeStk[LINK_W'(freeCnt - FREE_W'(1))];
    spAfter  = freeCnt - FREE_W'(strobe.doUpd);
    // same-arc pop drains the arc, so the append restarts it
    emptiesU = strobe.doDisp && (updNode == headNode) && singleVec[uIdx];
    headOpA  = linkVal[freedA];
    headOpB  = linkVal[freedB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opPres  <= '0;
      freeCnt <= FREE_W'(LINKS);
      rqRd    <= '0;
      rqWr    <= '0;
      rqCnt   <= '0;
      for (int i = 0; i < OPS; i++) begin
        opHead[i] <= '0;
        opTail[i] <= '0;
      end
      for (int i = 0; i < LINKS; i++) freeStk[i] <= LINK_W'(i);
      for (int i = 0; i < RQ_DEPTH; i++) rq[i] <= '0;
    end else begin
      if (strobe.doDisp) begin
        if (singleVec[dIdxA]) opPres[dIdxA] <= 1'b0;
        else                  opHead[dIdxA] <= linkNxt[freedA];
        if (singleVec[dIdxB]) opPres[dIdxB] <= 1'b0;
        else                  opHead[dIdxB] <= linkNxt[freedB];
        freeStk[LINK_W'(spAfter)]               <= freedA;
        freeStk[LINK_W'(spAfter + FREE_W'(1))]  <= freedB;
        rqRd <= rqRd + RQ_W'(1);
      end
      if (strobe.doUpd) begin
        if (!opPres[uIdx] || emptiesU) begin
          opPres[uIdx] <= 1'b1;
          opHead[uIdx] <= allocIdx;
        end
        opTail[uIdx] <= allocIdx;
      end
      if (strobe.pushDisp) rq[rqWr] <= headNode;
      if (strobe.pushUpd)  rq[rqWr + RQ_W'(strobe.pushDisp)] <= updNode;
      rqWr    <= rqWr + RQ_W'(strobe.pushDisp) + RQ_W'(strobe.pushUpd);
      rqCnt   <= rqCnt + RQ_CW'(strobe.pushDisp) + RQ_CW'(strobe.pushUpd)
               - RQ_CW'(strobe.doDisp);
      freeCnt <= spAfter + (strobe.doDisp ? FREE_W'(2) : FREE_W'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doUpd) begin
      linkVal[allocIdx] <= updPtr;
      if (opPres[uIdx] && !emptiesU) linkNxt[opTail[uIdx]] <= allocIdx;
    end
  end

  AST_RQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rqCnt <= RQ_CW'(RQ_DEPTH)); // R9
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freeCnt <= FREE_W'(LINKS)); // R8
  AST_DISP_BOTH_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doDisp |-> (opPres[dIdxA] && opPres[dIdxB])); // R2
  AST_UPD_MARKS_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doUpd |=> opPres[$past(uIdx)]); // R3
  AST_TAIL_IS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doUpd |=> (opTail[$past(uIdx)] == $past(allocIdx))); // R7
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rqCnt == '0) |=> (rqCnt <= RQ_CW'(2))); // R10
endmodule

// File: rtl/vec_arc_queue.sv
module vec_arc_queue
  import vaq_pkg::*;
#(
  parameter int NODES    = 8,
  parameter int PTR_W    = 8,
  parameter int LINKS    = 16,
  parameter int RQ_DEPTH = 4,
  localparam int NODE_W  = $clog2(NODES),
  localparam int OPS     = 2 * NODES,
  localparam int RQ_CW   = $clog2(RQ_DEPTH) + 1,
  localparam int FREE_W  = $clog2(LINKS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updValid,
  output logic              updReady,
  input  logic [NODE_W-1:0] updNode,
  input  logic              updPort,
  input  logic [PTR_W-1:0]  updPtr,
  output logic              rdyValid,
  output logic [NODE_W-1:0] rdyNode,
  output logic [PTR_W-1:0]  rdyOpA,
  output logic [PTR_W-1:0]  rdyOpB,
  input  logic              rdyPop
);
  vaqStrobe_t        strobe;
  logic [OPS-1:0]    presVec;
  logic [OPS-1:0]    singleVec;
  logic [RQ_CW-1:0]  rqCnt;
  logic [FREE_W-1:0] freeCnt;

  vaq_ctrl #(.NODES(NODES), .LINKS(LINKS), .RQ_DEPTH(RQ_DEPTH)) u_ctrl (
    .updValid (updValid),
    .updNode  (updNode),
    .updPort  (updPort),
    .rdyPop   (rdyPop),
    .presVec  (presVec),
    .singleVec(singleVec),
    .headNode (rdyNode),
    .rqCnt    (rqCnt),
    .freeCnt  (freeCnt),
    .updReady (updReady),
    .strobe   (strobe)
  );

  vaq_dpath #(.NODES(NODES), .PTR_W(PTR_W), .LINKS(LINKS), .RQ_DEPTH(RQ_DEPTH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .updNode  (updNode),
    .updPort  (updPort),
    .updPtr   (updPtr),
    .presVec  (presVec),
    .singleVec(singleVec),
    .headNode (rdyNode),
    .rqCnt    (rqCnt),
    .freeCnt  (freeCnt),
    .headOpA  (rdyOpA),
    .headOpB  (rdyOpB)
  );

  assign rdyValid = (rqCnt != '0);
endmodule

// File: tb/vec_arc_queue_tb.sv
module vec_arc_queue_tb;
  localparam int NODES = 8;
  localparam int LINKS = 16;
  localparam int RQD   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       updValid = 1'b0;
  logic [2:0] updNode = '0;
  logic       updPort = 1'b0;
  logic [7:0] updPtr = '0;
  logic       rdyPop = 1'b0;
  logic       updReady, rdyValid;
  logic [2:0] rdyNode;
  logic [7:0] rdyOpA, rdyOpB;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  // behavioural reference: one queue per arc, one queue of ready nodes
  int aq [2*NODES][$];
  int rq [$];

  always #5 clk = ~clk;

  vec_arc_queue #(.NODES(NODES), .PTR_W(8), .LINKS(LINKS), .RQ_DEPTH(RQD)) u_dut (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updReady(updReady),
    .updNode(updNode), .updPort(updPort), .updPtr(updPtr),
    .rdyValid(rdyValid), .rdyNode(rdyNode), .rdyOpA(rdyOpA), .rdyOpB(rdyOpB),
    .rdyPop(rdyPop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int total();
    int t = 0;
    for (int i = 0; i < 2*NODES; i++) t += aq[i].size();
    return t;
  endfunction

  function automatic bit mReady();
    return (total() < LINKS) && (rq.size() < RQD);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2*NODES; i++) aq[i].delete();
      rq.delete();
    end else begin
      bit uAcc, dAcc, uBefore;
      int ui, uo, d;
      uAcc = updValid && mReady();
      dAcc = rdyPop && (rq.size() > 0);
      ui = updNode * 2 + updPort;
      uo = updNode * 2 + (1 - updPort);
      uBefore = aq[ui].size() > 0 && aq[uo].size() > 0;
      d = -1;
      if (dAcc) begin
        d = rq.pop_front();
        void'(aq[2*d].pop_front());
        void'(aq[2*d+1].pop_front());
      end
      if (uAcc) aq[ui].push_back(updPtr);
      if (dAcc && aq[2*d].size() > 0 && aq[2*d+1].size() > 0) rq.push_back(d);
      if (uAcc && d != int'(updNode) && !uBefore
          && aq[ui].size() > 0 && aq[uo].size() > 0)
        rq.push_back(updNode);
    end
  end

  // every cycle: outputs against the model (R2, R3, R8)
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 rdyValid", rdyValid, rq.size() > 0);
      chk("R8 updReady", updReady, mReady());
      if (rq.size() > 0) begin
        chk("R2 rdyNode", rdyNode, rq[0]);
        chk("R3 rdyOpA", rdyOpA, aq[2*rq[0]][0]);
        chk("R3 rdyOpB", rdyOpB, aq[2*rq[0]+1][0]);
      end
    end
  end

  task automatic drive(input bit uv, input int n, input int p, input int ptr, input bit pop);
    @(negedge clk);
    updValid = uv; updNode = 3'(n); updPort = p[0]; updPtr = 8'(ptr); rdyPop = pop;
    @(negedge clk);
    updValid = 1'b0; rdyPop = 1'b0;
  endtask

  task automatic upd(input int n, input int p, input int ptr);
    drive(1, n, p, ptr, 0);
  endtask

  task automatic pop();
    drive(0, 0, 0, 0, 1);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdyValid", rdyValid, 0);
    chk("R1 updReady", updReady, 1);
  endtask

  function automatic void summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    doReset();
    // R2: single operand does not enable, second does
    upd(1, 0, 10);
    chk("R2 one operand", rdyValid, 0);
    upd(1, 1, 20);
    chk("R2 enabled", rdyValid, 1);
    chk("R2 node", rdyNode, 1);
    chk("R3 opA", rdyOpA, 10);
    chk("R3 opB", rdyOpB, 20);
    // R3/R4/R5: queue more, dispatch, re-enqueue, run dry
    upd(1, 0, 11); upd(1, 0, 12); upd(1, 1, 21);
    pop();
    chk("R4 reenq", rdyValid, 1);
    chk("R4 opA", rdyOpA, 11);
    chk("R4 opB", rdyOpB, 21);
    pop();
    chk("R5 dry", rdyValid, 0);
    upd(1, 1, 22);
    chk("R5 reenable", rdyValid, 1);
    chk("R5 opA", rdyOpA, 12);
    chk("R5 opB", rdyOpB, 22);
    pop();
    chk("R5 empty", rdyValid, 0);

    // R6: ordering with simultaneous re-enqueue and enable
    doReset();
    upd(2, 0, 30); upd(2, 1, 31); upd(3, 0, 40); upd(3, 1, 41);
    upd(2, 0, 32); upd(2, 1, 33); upd(4, 0, 45);
    chk("R6 head", rdyNode, 2);
    drive(1, 4, 1, 46, 1);
    chk("R6 first", rdyNode, 3);
    pop();
    chk("R6 second", rdyNode, 2);
    chk("R6 opA", rdyOpA, 32);
    pop();
    chk("R6 third", rdyNode, 4);
    chk("R6 opB", rdyOpB, 46);
    pop();
    chk("R6 drained", rdyValid, 0);

    // R7: dispatch and update on the same arc in one cycle
    doReset();
    upd(5, 0, 50); upd(5, 1, 60);
    drive(1, 5, 0, 51, 1);
    chk("R7 no enable", rdyValid, 0);
    upd(5, 1, 61);
    chk("R7 opA", rdyOpA, 51);
    chk("R7 opB", rdyOpB, 61);
    upd(5, 0, 52);
    drive(1, 5, 0, 53, 1);
    chk("R7 dry B", rdyValid, 0);
    upd(5, 1, 62);
    chk("R7 opA2", rdyOpA, 52);
    pop();
    upd(5, 1, 63);
    chk("R7 opA3", rdyOpA, 53);
    chk("R7 opB3", rdyOpB, 63);
    pop();

    // R10: pop on empty queue ignored
    pop();
    chk("R10 valid", rdyValid, 0);
    chk("R10 ready", updReady, 1);
    upd(6, 0, 70); upd(6, 1, 71);
    chk("R10 node", rdyNode, 6);
    pop();
    chk("R10 after", rdyValid, 0);

    // R9: ready queue full stalls updates
    doReset();
    for (int n = 0; n < 4; n++) begin
      upd(n, 0, 80 + n); upd(n, 1, 90 + n);
    end
    chk("R9 stall", updReady, 0);
    drive(1, 4, 0, 99, 1);
    chk("R9 resume", updReady, 1);
    upd(4, 1, 98);
    pop(); pop(); pop();
    chk("R9 not taken", rdyValid, 0);

    // R8: link table exhausted
    doReset();
    for (int i = 0; i < LINKS; i++) upd(7, 0, 100 + i);
    chk("R8 stall", updReady, 0);
    upd(7, 1, 200);
    chk("R8 not taken", rdyValid, 0);

    @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule